// File: doc/BRIEF.md
# Sector Header Target Search Unit

This unit follows the three-byte address header (minute, second, frame, all BCD) of each decoded sector and looks for a programmed target address. While the search is running, every valid header is compared with the target. The unit reports four things. It reports a match. It reports a header that has already passed the target, as an early warning. It reports a search that runs out of a programmed number of comparisons. After a match, it reports any sector that breaks the sequence.

Once the target has been found, the unit advances the target by one sector address on every header. This makes each later header the expected successor of the one before. Events are collected in a status byte whose event flags clear when the byte is read. The two failure events can raise a shared interrupt request. They can also drop the decoder-enable bit so that decoding stops without firmware action.

At the end of each sector's error check, the unit also flags two conditions. One is a nonzero block indicator, when that check is unmasked. The other is a decoded-sector count that has reached a programmed threshold.

Top module: `hdr_seek_top`

## Requirements
- R1: Synchronous reset (`rst_n` low) clears the status byte, `irq` and every register, so `dec_en` is 0. A `soft_clr` pulse clears the status byte, `irq` and the comparison counter, and leaves the other registers unchanged.
- R2: While the search-enable bit (control bit 7) is 1 and the found bit (status bit 7) is 0, a header equal to the target sets status bit 7.
- R3: Before the target is found, a header greater than the target sets status bit 2. The comparison is unsigned over minute, then second, then frame. The flag is set only when control bits 7 and 2 are both 1.
- R4: Each mismatching header counts one comparison before the target is found. When the count reaches the search limit (register address 4), status bit 1 sets once and counting stops. A limit of 0 never fires. Enabling the search (control bit 7 going from 0 to 1) or writing any target byte restarts the count.
- R5: `irq` rises when status bit 1 sets with control bit 1 high, or when status bit 0 sets with control bit 0 high. It falls on a status read.
- R6: While control bit 3 is 0, setting status bit 1 or bit 0 clears the decoder-enable bit (control bit 5, output `dec_en`). While control bit 3 is 1, `dec_en` is kept.
- R7: On the matching header and on every header after it, the target advances by one. Frame 74 wraps to 00 and carries into the second. Second 59 wraps to 00 and carries into the minute. Minute 99 wraps to 00.
- R8: After the target is found, a header that differs from the advanced target sets status bit 0.
- R9: A status read (`rd_en`) returns the status byte on `rd_data` and clears bits 6 to 0. Bit 7 is kept.
- R10: When an event and a status read fall in the same cycle, the event's flag is set after that cycle, and so is `irq` if the event raises it.
- R11: On `edc_done`, when the block mask (control bit 4) is 1 and the last header's block indicator is nonzero, status bits 6 and 5 set.
- R12: On `edc_done`, when control bit 6 is 1 and `sec_cnt` equals the threshold (register address 5), status bit 4 sets.
- R13: Writing any target byte (addresses 1 to 3 hold minute, second, frame), or enabling the search, clears status bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low chip reset |
| soft_clr | input | 1 | Host, firmware or decoder reset pulse |
| hdr_vld | input | 1 | Header bytes valid strobe |
| hdr_min | input | 8 | Header minute (BCD) |
| hdr_sec | input | 8 | Header second (BCD) |
| hdr_frm | input | 8 | Header frame (BCD) |
| hdr_blk | input | 3 | Header block indicator |
| edc_done | input | 1 | End of sector error check strobe |
| sec_cnt | input | CNT_W | Decoded-sector count |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register address: 0 control, 1-3 target, 4 limit, 5 threshold |
| wr_data | input | 8 | Register write data |
| rd_en | input | 1 | Status read strobe (clears event flags) |
| rd_data | output | 8 | Status byte |
| irq | output | 1 | Interrupt request |
| dec_en | output | 1 | Decoder enable (control bit 5) |

## Verification
Every result, whether from a header strobe, an `edc_done` pulse, a register write or a status read, is registered. It therefore appears on `rd_data`, `irq` and `dec_en` one clock after the rising edge that captured the strobe. The bench drives each strobe on a falling edge and removes it on the next falling edge. At that point the capturing rising edge has passed, so the check is made there. A status read is checked the same way: the cleared value is sampled one falling edge after the read strobe. The collision case drives the read and the header on the same falling edge and checks that the flag survives.

// File: rtl/hdr_seek_pkg.sv
// Shared types and helpers for the sector header target search unit.
// Assumes header and target bytes hold two packed BCD digits.
package hdr_seek_pkg;

    // Sector address as minute, second, frame (MSB first, so a vector
    // compare orders addresses correctly).
    typedef struct packed {
        logic [7:0] mm;
        logic [7:0] ss;
        logic [7:0] ff;
    } msf_t;

    // Control register layout (bit 7 down to bit 0).
    typedef struct packed {
        logic search_en;
        logic count_en;
        logic dec_en;
        logic blk_mask;
        logic auto_stop_n;
        logic ltt_en;
        logic tnf_en;
        logic hce_en;
    } ctl_t;

    localparam int A_CTL = 0;
    localparam int A_TMM = 1;
    localparam int A_TSS = 2;
    localparam int A_TFF = 3;
    localparam int A_LIM = 4;
    localparam int A_THR = 5;

    // Status bit positions.
    localparam int S_FOUND = 7;
    localparam int S_ERR   = 6;
    localparam int S_BLK   = 5;
    localparam int S_FULL  = 4;
    localparam int S_LTT   = 2;
    localparam int S_TNF   = 1;
    localparam int S_HCE   = 0;

    // One BCD byte step: returns {carry_out, next}; wraps at 'last'.
    function automatic logic [8:0] bcd_step(input logic [7:0] v, input logic [7:0] last);
        if (v == last)
            return {1'b1, 8'h00};
        else if (v[3:0] == 4'd9)
            return {1'b0, v[7:4] + 4'd1, 4'd0};
        else
            return {1'b0, v[7:4], v[3:0] + 4'd1};
    endfunction

endpackage

// File: rtl/hdr_msf_inc.sv
// Advances a BCD sector address by one frame.
// Assumes a valid BCD input; each field wraps at its own last value.
module hdr_msf_inc
    import hdr_seek_pkg::*;
#(
    parameter logic [7:0] FRM_LAST = 8'h74,
    parameter logic [7:0] SEC_LAST = 8'h59,
    parameter logic [7:0] MIN_LAST = 8'h99
) (
    input  msf_t cur,
    output msf_t nxt
);
    logic [8:0] f_r, s_r, m_r;

    // Ripple the carry from frame through second into minute.
    always_comb begin
        f_r = bcd_step(cur.ff, FRM_LAST);
        s_r = f_r[8] ? bcd_step(cur.ss, SEC_LAST) : {1'b0, cur.ss};
        m_r = s_r[8] ? bcd_step(cur.mm, MIN_LAST) : {1'b0, cur.mm};
        nxt = '{mm: m_r[7:0], ss: s_r[7:0], ff: f_r[7:0]};
    end
endmodule

// File: rtl/hdr_msf_cmp.sv
// Compares a header address with the target address.
// Assumes packed BCD, so the unsigned vector order equals time order.
module hdr_msf_cmp
    import hdr_seek_pkg::*;
(
    input  msf_t hdr,
    input  msf_t tgt,
    output logic eq,
    output logic gt
);
    // Equality and magnitude, minute most significant.
    always_comb begin
        eq = (hdr == tgt);
        gt = (hdr > tgt);
    end
endmodule

// File: rtl/hdr_seek_top.sv
// Sector header target search unit: bounded search, overshoot warning,
// sequential tracking with auto-advancing target, read-to-clear status,
// interrupt request and optional automatic decoder stop.
// Assumes single-cycle strobes and one register access per cycle.
module hdr_seek_top
    import hdr_seek_pkg::*;
#(
    parameter int LIM_W  = 8,
    parameter int CNT_W  = 8,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_clr,
    input  logic              hdr_vld,
    input  logic [7:0]        hdr_min,
    input  logic [7:0]        hdr_sec,
    input  logic [7:0]        hdr_frm,
    input  logic [2:0]        hdr_blk,
    input  logic              edc_done,
    input  logic [CNT_W-1:0]  sec_cnt,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              rd_en,
    output logic [7:0]        rd_data,
    output logic              irq,
    output logic              dec_en
);
    localparam logic [7:0] EVT_MASK = 8'h7F;

    ctl_t             ctl;
    msf_t             tgt, tgt_nxt, hdr;
    logic [LIM_W-1:0] lim, cmp_cnt, cnt_inc;
    logic [CNT_W-1:0] thresh;
    logic [2:0]       blk_q;
    logic [7:0]       status, set_bits;
    logic             eq, gt, found;
    logic             wr_ctl, wr_tgt, restart, hdr_take, cnt_live;
    logic             ev_found, ev_ltt, ev_tnf, ev_hce, ev_blk, ev_full;
    logic             irq_set, stop;

    assign hdr     = '{mm: hdr_min, ss: hdr_sec, ff: hdr_frm};
    assign found   = status[S_FOUND];
    assign rd_data = status;
    assign dec_en  = ctl.dec_en;

    hdr_msf_cmp u_cmp (.hdr(hdr), .tgt(tgt), .eq(eq), .gt(gt));
    hdr_msf_inc u_inc (.cur(tgt), .nxt(tgt_nxt));

    // Decode register writes and search events for this cycle.
    always_comb begin
        wr_ctl   = wr_en && (wr_addr == ADDR_W'(A_CTL));
        wr_tgt   = wr_en && (wr_addr >= ADDR_W'(A_TMM)) && (wr_addr <= ADDR_W'(A_TFF));
        restart  = wr_tgt || (wr_ctl && wr_data[7] && !ctl.search_en);
        hdr_take = hdr_vld && ctl.search_en;
        cnt_inc  = cmp_cnt + 1'b1;
        cnt_live = (lim == '0) || (cmp_cnt != lim);
        ev_found = hdr_take && !found && eq;
        ev_ltt   = hdr_take && !found && gt && ctl.ltt_en;
        ev_tnf   = hdr_take && !found && !eq && (lim != '0) && (cmp_cnt != lim) && (cnt_inc == lim);
        ev_hce   = hdr_take && found && !eq;
        ev_blk   = edc_done && ctl.blk_mask && (blk_q != 3'd0);
        ev_full  = edc_done && ctl.count_en && (sec_cnt == thresh);
        set_bits = {ev_found, ev_blk, ev_blk, ev_full, 1'b0, ev_ltt, ev_tnf, ev_hce};
        irq_set  = (ev_tnf && ctl.tnf_en) || (ev_hce && ctl.hce_en);
        stop     = (ev_tnf || ev_hce) && !ctl.auto_stop_n;
    end

    // Control, limit and threshold registers; auto-stop overrides a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl    <= '0;
            lim    <= '0;
            thresh <= '0;
        end else begin
            if (wr_ctl) ctl <= ctl_t'(wr_data);
            if (wr_en && wr_addr == ADDR_W'(A_LIM)) lim    <= LIM_W'(wr_data);
            if (wr_en && wr_addr == ADDR_W'(A_THR)) thresh <= CNT_W'(wr_data);
            if (stop) ctl.dec_en <= 1'b0;
        end
    end

    // Target register: firmware write, else advance while tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt <= '0;
        end else if (wr_tgt) begin
            if (wr_addr == ADDR_W'(A_TMM)) tgt.mm <= wr_data;
            if (wr_addr == ADDR_W'(A_TSS)) tgt.ss <= wr_data;
            if (wr_addr == ADDR_W'(A_TFF)) tgt.ff <= wr_data;
        end else if (hdr_take && (found || eq)) begin
            tgt <= tgt_nxt;
        end
    end

    // Successive-mismatch counter; holds once the limit is reached.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr || restart)
            cmp_cnt <= '0;
        else if (hdr_take && !found && !eq && cnt_live)
            cmp_cnt <= cnt_inc;
    end

    // Block indicator of the most recent header, used at error-check end.
    always_ff @(posedge clk) begin
        if (!rst_n)       blk_q <= '0;
        else if (hdr_vld) blk_q <= hdr_blk;
    end

    // Status byte: read clears event flags, a new event wins over the read.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) begin
            status <= '0;
        end else begin
            status <= (status & ~(rd_en ? EVT_MASK : 8'h00)) | set_bits;
            status[S_FOUND] <= !restart && (found || ev_found);
        end
    end

    // Interrupt request: set by enabled failure events, dropped by a read.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) irq <= 1'b0;
        else if (irq_set)       irq <= 1'b1;
        else if (rd_en)         irq <= 1'b0;
    end

    // R2
    found_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[S_FOUND]) |-> $past(hdr_vld));
    // R4
    tnf_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[S_TNF]) |-> $past(hdr_vld) && $past(cmp_cnt) != $past(lim));
    // R5
    irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(rd_en || soft_clr));
    // R6
    dec_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dec_en) |-> $past(wr_en) || !$past(ctl.auto_stop_n));
    // R9
    evt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(status[6:0]) & ~status[6:0])) |-> $past(rd_en || soft_clr));
endmodule

// File: tb/hdr_seek_top_bench.sv
module hdr_seek_top_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       soft_clr = 1'b0;
    logic       hdr_vld = 1'b0;
    logic [7:0] hdr_min = '0, hdr_sec = '0, hdr_frm = '0;
    logic [2:0] hdr_blk = '0;
    logic       edc_done = 1'b0;
    logic [7:0] sec_cnt = '0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       irq, dec_en;
    int         n_chk = 0;
    int         n_fail = 0;

    always #5 clk = ~clk;

    hdr_seek_top u_hdr_seek_top (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .hdr_vld(hdr_vld),
        .hdr_min(hdr_min), .hdr_sec(hdr_sec), .hdr_frm(hdr_frm), .hdr_blk(hdr_blk),
        .edc_done(edc_done), .sec_cnt(sec_cnt), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .irq(irq), .dec_en(dec_en));

    // {header[23:0], expected status[7:0], expected irq, read after}
    localparam logic [33:0] VEC [0:8] = '{
        {24'h000265, 8'h00, 1'b0, 1'b0},
        {24'h000272, 8'h04, 1'b0, 1'b1},
        {24'h000270, 8'h80, 1'b0, 1'b0},
        {24'h000271, 8'h80, 1'b0, 1'b0},
        {24'h000272, 8'h80, 1'b0, 1'b0},
        {24'h000273, 8'h80, 1'b0, 1'b0},
        {24'h000274, 8'h80, 1'b0, 1'b0},
        {24'h000300, 8'h80, 1'b0, 1'b0},
        {24'h000305, 8'h81, 1'b1, 1'b1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd();
        @(negedge clk); rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic hdr(input logic [23:0] a, input logic [2:0] b);
        @(negedge clk); hdr_vld = 1'b1; {hdr_min, hdr_sec, hdr_frm} = a; hdr_blk = b;
        @(negedge clk); hdr_vld = 1'b0;
    endtask

    task automatic edc(input logic [7:0] c);
        @(negedge clk); edc_done = 1'b1; sec_cnt = c;
        @(negedge clk); edc_done = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 status", {24'h0, rd_data}, 32'h00);
        check("R1 irq", {31'h0, irq}, 32'h0);
        check("R1 dec_en", {31'h0, dec_en}, 32'h0);
        rst_n = 1'b1;

        // Table: limit 4, target 00:02:70, search+dec_en+no-stop+ltt+tnf+hce
        wr(4, 8'd4); wr(1, 8'h00); wr(2, 8'h02); wr(3, 8'h70); wr(0, 8'hAF);
        for (int i = 0; i < 9; i++) begin
            hdr(VEC[i][33:10], 3'd0);
            check("R2/R3/R7/R8 table status", {24'h0, rd_data}, {24'h0, VEC[i][9:2]});
            check("R5 table irq", {31'h0, irq}, {31'h0, VEC[i][1]});
            if (VEC[i][0]) begin
                rd();
                check("R9 read clears", {24'h0, rd_data}, {24'h0, VEC[i][9:2] & 8'h80});
                check("R5 read drops irq", {31'h0, irq}, 32'h0);
            end
        end
        check("R6 no stop when bit3 high", {31'h0, dec_en}, 32'h1);

        // Not-found path with auto stop: target 10:00:00, limit 3
        wr(0, 8'h20); wr(1, 8'h10); wr(2, 8'h00); wr(3, 8'h00);
        check("R13 target write clears found", {24'h0, rd_data}, 32'h00);
        wr(4, 8'd3); wr(0, 8'hA2);
        hdr(24'h000001, 3'd0); hdr(24'h000001, 3'd0);
        check("R4 below limit", {24'h0, rd_data}, 32'h00);
        hdr(24'h000001, 3'd0);
        check("R4 limit reached", {24'h0, rd_data}, 32'h02);
        check("R5 tnf irq", {31'h0, irq}, 32'h1);
        check("R6 auto stop on tnf", {31'h0, dec_en}, 32'h0);
        hdr(24'h200000, 3'd0);
        check("R3 ltt disabled", {24'h0, rd_data}, 32'h02);
        rd();
        hdr(24'h000001, 3'd0);
        check("R4 fires once", {24'h0, rd_data}, 32'h00);

        // Collision: event and read in the same cycle
        wr(0, 8'h00); wr(4, 8'd1); wr(0, 8'h8A);
        @(negedge clk); hdr_vld = 1'b1; {hdr_min, hdr_sec, hdr_frm} = 24'h000001; rd_en = 1'b1;
        @(negedge clk); hdr_vld = 1'b0; rd_en = 1'b0;
        check("R10 event beats read", {24'h0, rd_data}, 32'h02);
        check("R10 irq kept", {31'h0, irq}, 32'h1);
        rd();

        // Full wrap and compare error with auto stop
        wr(0, 8'h00); wr(1, 8'h99); wr(2, 8'h59); wr(3, 8'h74); wr(0, 8'hA1);
        hdr(24'h995974, 3'd0);
        check("R2 found", {24'h0, rd_data}, 32'h80);
        hdr(24'h000000, 3'd0);
        check("R7 wrap 99:59:74", {24'h0, rd_data}, 32'h80);
        hdr(24'h000005, 3'd0);
        check("R8 sequence break", {24'h0, rd_data}, 32'h81);
        check("R6 auto stop on hce", {31'h0, dec_en}, 32'h0);
        check("R5 hce irq", {31'h0, irq}, 32'h1);
        rd();

        // End of error check conditions
        wr(0, 8'h50); wr(5, 8'd7);
        hdr(24'h000000, 3'd3); edc(8'd7);
        check("R11/R12 edc flags", {24'h0, rd_data}, 32'hF0);
        rd();
        hdr(24'h000000, 3'd0); edc(8'd6);
        check("R11/R12 no condition", {24'h0, rd_data}, 32'h80);
        wr(0, 8'h40);
        hdr(24'h000000, 3'd5); edc(8'd7);
        check("R11 mask off, R12 count", {24'h0, rd_data}, 32'h90);

        @(negedge clk); soft_clr = 1'b1;
        @(negedge clk); soft_clr = 1'b0;
        check("R1 soft clear status", {24'h0, rd_data}, 32'h00);
        check("R1 soft clear irq", {31'h0, irq}, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule